// File: doc/BRIEF.md
# Two-Operand ALU with Branch Comparator

This block is the execute-stage arithmetic unit of a small 16-bit core that uses destructive two-operand instructions. Operand A is always the current value of the destination register. Operand B is either the second source register or the sign-extended 7-bit immediate, and the decoder picks which one. The block returns the value to be written back for add, subtract, signed and unsigned set-less-than, the three shifts, the three bitwise operations and move/load-immediate.

In the same cycle, and from the same two operands, it evaluates one of eight branch conditions and raises a taken flag. Two of those conditions test operand A against zero and take no notice of operand B. The shift amount arrives on its own full-width input, which carries either the rs2 value or the immediate, and only its low four bits are used.

Both outputs are registered. A set of inputs presented before a rising clock edge produces its result right after that edge. Register write-back and program-counter arithmetic belong to other blocks.

Top module: `alu2_top`

## Requirements
- R1: Operation code 0 (add) returns A+B and code 1 (subtract) returns A-B, both modulo 2^16, with no carry or overflow output.
- R2: Code 2 returns 1 when A < B as signed two's-complement values, otherwise 0.
- R3: Code 3 returns 1 when A < B as unsigned values, otherwise 0. With B = 0xFFFF (a sign-extended immediate of -1) it returns 1 for every A except 0xFFFF.
- R4: Shifts use only bits [3:0] of the shift-amount input (0 to 15), and bits [15:4] have no effect on the result.
- R5: Code 4 shifts A left and fills with zeros. Code 5 shifts A right and fills with zeros. Code 6 shifts A right and copies bit 15 of A into the vacated positions.
- R6: Code 7 returns A|B, code 8 returns A&B and code 9 returns A^B.
- R7: Code 10 (move / load-immediate) returns B whatever the value of A.
- R8: The branch select sets the taken flag from A and B: 000 A==B, 001 A!=B, 100 signed A<B, 101 signed A>=B, 110 unsigned A<B, 111 unsigned A>=B.
- R9: Branch select 010 is taken when A==0 and select 011 is taken when A!=0. In both cases B has no effect.
- R10: While rst_n is low, result and taken are 0. Otherwise both outputs take the values for the inputs sampled at each rising clock edge and show them immediately after that edge.
- R11: Operation codes 11 to 15 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_sel | input | 4 | Operation code (R1 to R7, R11) |
| br_sel | input | 3 | Branch condition code (R8, R9) |
| opnd_a | input | 16 | Destination register value / rs1 for branches |
| opnd_b | input | 16 | rs2 value or sign-extended immediate |
| shamt | input | 16 | Shift source; only bits [3:0] are used |
| result | output | 16 | Registered operation result |
| taken | output | 1 | Registered branch-taken flag |

## Verification
Every result and taken flag is due exactly one rising edge after its inputs are presented. The driver changes inputs on the falling edge and queues the expected pair. The monitor takes one entry from the queue a quarter period after each rising edge, so each comparison reads the register loaded from the previous falling-edge stimulus and never the current one. The reset values are sampled at falling edges while rst_n is low, before any stimulus is queued.

// File: rtl/alu2_pkg.sv
package alu2_pkg;
    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_SLT  = 4'd2,
        OP_SLTU = 4'd3,
        OP_SLL  = 4'd4,
        OP_SRL  = 4'd5,
        OP_SRA  = 4'd6,
        OP_OR   = 4'd7,
        OP_AND  = 4'd8,
        OP_XOR  = 4'd9,
        OP_MOVE = 4'd10
    } alu_op_e;

    typedef enum logic [2:0] {
        BR_EQ      = 3'd0,
        BR_NE      = 3'd1,
        BR_ZERO    = 3'd2,
        BR_NONZERO = 3'd3,
        BR_LT      = 3'd4,
        BR_GE      = 3'd5,
        BR_LTU     = 3'd6,
        BR_GEU     = 3'd7
    } br_cond_e;
endpackage

// File: rtl/alu2_arith.sv
module alu2_arith
    import alu2_pkg::*;
#(
    parameter int W = 16
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [W-1:0]   res
);
    logic lt_s;
    logic lt_u;

    always_comb begin
        lt_s = $signed(a) < $signed(b);
        lt_u = a < b;
        unique case (op)
            OP_ADD:  res = a + b;
            OP_SUB:  res = a - b;
            OP_SLT:  res = {{(W-1){1'b0}}, lt_s};
            OP_SLTU: res = {{(W-1){1'b0}}, lt_u};
            OP_OR:   res = a | b;
            OP_AND:  res = a & b;
            OP_XOR:  res = a ^ b;
            OP_MOVE: res = b;
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/alu2_shift.sv
module alu2_shift
    import alu2_pkg::*;
#(
    parameter int W   = 16,
    parameter int SHW = $clog2(W)
) (
    input  alu_op_e          op,
    input  logic [W-1:0]     a,
    input  logic [SHW-1:0]   sh,
    output logic [W-1:0]     res
);
    always_comb begin
        unique case (op)
            OP_SLL:  res = a << sh;
            OP_SRL:  res = a >> sh;
            OP_SRA:  res = W'($signed(a) >>> sh);
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/alu2_brcmp.sv
module alu2_brcmp
    import alu2_pkg::*;
#(
    parameter int W = 16
) (
    input  br_cond_e       cond,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic           take
);
    logic eq, lt_s, lt_u, a_zero;

    always_comb begin
        eq     = (a == b);
        lt_s   = $signed(a) < $signed(b);
        lt_u   = a < b;
        a_zero = (a == '0);
        unique case (cond)
            BR_EQ:      take = eq;
            BR_NE:      take = !eq;
            BR_ZERO:    take = a_zero;
            BR_NONZERO: take = !a_zero;
            BR_LT:      take = lt_s;
            BR_GE:      take = !lt_s;
            BR_LTU:     take = lt_u;
            BR_GEU:     take = !lt_u;
            default:    take = 1'b0;
        endcase
    end
endmodule

// File: rtl/alu2_top.sv
module alu2_top
    import alu2_pkg::*;
#(
    parameter int W   = 16,
    parameter int SHW = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [3:0]    op_sel,
    input  logic [2:0]    br_sel,
    input  logic [W-1:0]  opnd_a,
    input  logic [W-1:0]  opnd_b,
    input  logic [W-1:0]  shamt,
    output logic [W-1:0]  result,
    output logic          taken
);
    alu_op_e        op;
    br_cond_e       cond;
    logic [W-1:0]   arith_res;
    logic [W-1:0]   shift_res;
    logic [W-1:0]   res_d;
    logic           take_d;
    logic           is_shift;
    logic           unused_sh_hi;

    assign op           = alu_op_e'(op_sel);
    assign cond         = br_cond_e'(br_sel);
    assign unused_sh_hi = ^shamt[W-1:SHW];

    alu2_arith #(.W(W)) u_arith (
        .op  (op),
        .a   (opnd_a),
        .b   (opnd_b),
        .res (arith_res)
    );

    alu2_shift #(.W(W), .SHW(SHW)) u_shift (
        .op  (op),
        .a   (opnd_a),
        .sh  (shamt[SHW-1:0]),
        .res (shift_res)
    );

    alu2_brcmp #(.W(W)) u_br (
        .cond (cond),
        .a    (opnd_a),
        .b    (opnd_b),
        .take (take_d)
    );

    always_comb begin
        is_shift = (op == OP_SLL) || (op == OP_SRL) || (op == OP_SRA);
        res_d    = is_shift ? shift_res : arith_res;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result <= '0;
            taken  <= 1'b0;
        end else begin
            result <= res_d;
            taken  <= take_d;
        end
    end
endmodule

// File: rtl/alu2_chk.sv
module alu2_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [3:0]  op_sel,
    input logic [2:0]  br_sel,
    input logic [15:0] opnd_a,
    input logic [15:0] opnd_b,
    input logic [15:0] result,
    input logic        taken
);
    logic armed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    // R7: move returns operand B
    a_r7_move_takes_b: assert property (@(posedge clk) disable iff (!rst_n)
        armed && $past(op_sel) == 4'd10 |-> result == $past(opnd_b));

    // R9: zero test follows operand A only
    a_r9_zero_test: assert property (@(posedge clk) disable iff (!rst_n)
        armed && $past(br_sel) == 3'd2 |-> taken == ($past(opnd_a) == 16'h0000));

    // R2: set-less-than yields a single bit
    a_r2_slt_boolean: assert property (@(posedge clk) disable iff (!rst_n)
        armed && ($past(op_sel) == 4'd2 || $past(op_sel) == 4'd3) |-> result[15:1] == 15'd0);

    // R5: arithmetic right shift keeps the sign
    a_r5_sra_sign: assert property (@(posedge clk) disable iff (!rst_n)
        armed && $past(op_sel) == 4'd6 |-> result[15] == $past(opnd_a[15]));

    // R3: unsigned compare against all-ones
    a_r3_sltu_ones: assert property (@(posedge clk) disable iff (!rst_n)
        armed && $past(op_sel) == 4'd3 && $past(opnd_b) == 16'hFFFF
        |-> result[0] == ($past(opnd_a) != 16'hFFFF));

    // R11: unassigned codes give zero
    a_r11_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
        armed && $past(op_sel) > 4'd10 |-> result == 16'h0000);
endmodule

bind alu2_top alu2_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .op_sel (op_sel),
    .br_sel (br_sel),
    .opnd_a (opnd_a),
    .opnd_b (opnd_b),
    .result (result),
    .taken  (taken)
);

// File: tb/sim_alu2_top.sv
module sim_alu2_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op_sel = '0;
    logic [2:0]  br_sel = '0;
    logic [15:0] opnd_a = '0;
    logic [15:0] opnd_b = '0;
    logic [15:0] shamt = '0;
    logic [15:0] result;
    logic        taken;

    int n_cmp = 0;
    int n_bad = 0;

    logic [15:0] q_res[$];
    logic        q_tk[$];
    string       q_rreq[$];
    string       q_treq[$];

    always #10 clk = ~clk;

    alu2_top u0 (
        .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .br_sel(br_sel),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .shamt(shamt),
        .result(result), .taken(taken)
    );

    function automatic logic [15:0] model_res(logic [3:0] op, logic [15:0] a, logic [15:0] b, logic [15:0] s);
        int k;
        logic [15:0] r;
        k = int'(s[3:0]);
        case (op)
            4'd0:  r = a + b;
            4'd1:  r = a - b;
            4'd2:  r = ($signed(a) < $signed(b)) ? 16'd1 : 16'd0;
            4'd3:  r = (a < b) ? 16'd1 : 16'd0;
            4'd4:  r = a << k;
            4'd5:  r = a >> k;
            4'd6: begin
                r = a;
                for (int i = 0; i < k; i++) r = {r[15], r[15:1]};
            end
            4'd7:  r = a | b;
            4'd8:  r = a & b;
            4'd9:  r = a ^ b;
            4'd10: r = b;
            default: r = 16'd0;
        endcase
        return r;
    endfunction

    function automatic logic model_tk(logic [2:0] br, logic [15:0] a, logic [15:0] b);
        case (br)
            3'd0: return a == b;
            3'd1: return a != b;
            3'd2: return a == 16'd0;
            3'd3: return a != 16'd0;
            3'd4: return $signed(a) < $signed(b);
            3'd5: return $signed(a) >= $signed(b);
            3'd6: return a < b;
            default: return a >= b;
        endcase
    endfunction

    function automatic string req_of_op(logic [3:0] op);
        if (op <= 4'd1) return "R1";
        if (op == 4'd2) return "R2";
        if (op == 4'd3) return "R3";
        if (op <= 4'd6) return "R5";
        if (op <= 4'd9) return "R6";
        if (op == 4'd10) return "R7";
        return "R11";
    endfunction

    task automatic drive(input logic [3:0] op, input logic [2:0] br,
                         input logic [15:0] a, input logic [15:0] b,
                         input logic [15:0] s, input string rreq);
        @(negedge clk);
        op_sel = op; br_sel = br; opnd_a = a; opnd_b = b; shamt = s;
        q_res.push_back(model_res(op, a, b, s));
        q_tk.push_back(model_tk(br, a, b));
        q_rreq.push_back(rreq);
        q_treq.push_back((br == 3'd2 || br == 3'd3) ? "R9" : "R8");
    endtask

    // monitor: one entry per rising edge, sampled 5 ns later
    always @(posedge clk) begin
        #5;
        if (q_res.size() > 0) begin
            logic [15:0] er;
            logic        et;
            string       rr, tr;
            er = q_res.pop_front();
            et = q_tk.pop_front();
            rr = q_rreq.pop_front();
            tr = q_treq.pop_front();
            n_cmp++;
            if (result !== er) begin
                n_bad++;
                $display("FAIL %s result actual=%h expected=%h", rr, result, er);
            end
            n_cmp++;
            if (taken !== et) begin
                n_bad++;
                $display("FAIL %s taken actual=%b expected=%b", tr, taken, et);
            end
        end
    end

    initial begin
        #(20 * 100000);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] corners [5];
        corners[0] = 16'h0000; corners[1] = 16'h8000; corners[2] = 16'h7FFF;
        corners[3] = 16'hFFFF; corners[4] = 16'h0001;

        // R10: reset state
        repeat (3) @(negedge clk);
        n_cmp++;
        if (result !== 16'h0 || taken !== 1'b0) begin
            n_bad++;
            $display("FAIL R10 reset actual=%h/%b expected=0000/0", result, taken);
        end
        @(negedge clk); rst_n = 1'b1;

        // R1 wrap
        drive(4'd0, 3'd0, 16'hFFFF, 16'h0001, 16'h0, "R1");
        drive(4'd1, 3'd0, 16'h0000, 16'h0001, 16'h0, "R1");
        drive(4'd0, 3'd0, 16'h7FFF, 16'h0001, 16'h0, "R1");
        // R2 signed compare
        drive(4'd2, 3'd4, 16'h8000, 16'h7FFF, 16'h0, "R2");
        drive(4'd2, 3'd4, 16'h7FFF, 16'h8000, 16'h0, "R2");
        drive(4'd2, 3'd5, 16'h1234, 16'h1234, 16'h0, "R2");
        // R3 unsigned compare, all-ones immediate
        drive(4'd3, 3'd6, 16'h8000, 16'h7FFF, 16'h0, "R3");
        drive(4'd3, 3'd6, 16'h0005, 16'hFFFF, 16'h0, "R3");
        drive(4'd3, 3'd7, 16'hFFFF, 16'hFFFF, 16'h0, "R3");
        // R4 shift amount masking
        drive(4'd4, 3'd0, 16'h0001, 16'h0, 16'h0013, "R4");
        drive(4'd4, 3'd0, 16'h00A5, 16'h0, 16'h0010, "R4");
        drive(4'd5, 3'd0, 16'hF000, 16'h0, 16'hFFF4, "R4");
        // R5 fill rules
        drive(4'd6, 3'd0, 16'h8000, 16'h0, 16'h000F, "R5");
        drive(4'd5, 3'd0, 16'h8000, 16'h0, 16'h000F, "R5");
        drive(4'd6, 3'd0, 16'h4000, 16'h0, 16'h0002, "R5");
        drive(4'd4, 3'd0, 16'hFFFF, 16'h0, 16'h000F, "R5");
        drive(4'd6, 3'd0, 16'h8001, 16'h0, 16'h0000, "R5");
        // R6 bitwise
        drive(4'd7, 3'd1, 16'hF0F0, 16'h0FF0, 16'h0, "R6");
        drive(4'd8, 3'd1, 16'hF0F0, 16'h0FF0, 16'h0, "R6");
        drive(4'd9, 3'd1, 16'hF0F0, 16'h0FF0, 16'h0, "R6");
        // R7 move ignores A
        drive(4'd10, 3'd0, 16'h1234, 16'hBEEF, 16'h0, "R7");
        drive(4'd10, 3'd0, 16'hFFFF, 16'hFFC0, 16'h0, "R7");
        // R8 branch conditions
        drive(4'd0, 3'd0, 16'h5555, 16'h5555, 16'h0, "R1");
        drive(4'd0, 3'd1, 16'h5555, 16'h5555, 16'h0, "R1");
        drive(4'd0, 3'd4, 16'hFFFF, 16'h0000, 16'h0, "R1");
        drive(4'd0, 3'd5, 16'hFFFF, 16'h0000, 16'h0, "R1");
        drive(4'd0, 3'd6, 16'hFFFF, 16'h0000, 16'h0, "R1");
        drive(4'd0, 3'd7, 16'hFFFF, 16'h0000, 16'h0, "R1");
        // R9 zero tests ignore B
        drive(4'd10, 3'd2, 16'h0000, 16'h0005, 16'h0, "R7");
        drive(4'd10, 3'd3, 16'h0000, 16'h0005, 16'h0, "R7");
        drive(4'd10, 3'd2, 16'h0003, 16'h0000, 16'h0, "R7");
        drive(4'd10, 3'd3, 16'h8000, 16'h8000, 16'h0, "R7");
        // R11 unassigned codes
        for (int c = 11; c < 16; c++)
            drive(4'(c), 3'd0, 16'hABCD, 16'h1357, 16'h3, "R11");
        // mixed random and corner operands
        for (int n = 0; n < 400; n++) begin
            logic [3:0]  op;
            logic [15:0] a, b, s;
            op = 4'($urandom_range(0, 15));
            a  = (n % 3 == 0) ? corners[$urandom_range(0, 4)] : 16'($urandom());
            b  = (n % 4 == 0) ? corners[$urandom_range(0, 4)] : 16'($urandom());
            s  = (n % 5 == 0) ? 16'(($urandom_range(0, 1) != 0) ? 15 : 0) : 16'($urandom());
            drive(op, 3'($urandom_range(0, 7)), a, b, s, req_of_op(op));
        end
        @(negedge clk);
        @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule